// File: doc/BRIEF.md
# Almost-Flag Offset Programming Controller

This block sets up the four threshold values that a bidirectional FIFO pair uses for its almost-empty and almost-full flags. There is one almost-full and one almost-empty threshold on each side. When the shared reset is released, the block looks at a two-bit select input once. A non-zero select loads a fixed preset into all four thresholds, and the FIFO pair is ready at once. A zero select starts a programming phase. In that phase the next four words accepted on the port-A write stream are not passed to FIFO memory. Each one becomes the next threshold, in a fixed order.

The port-A write stream uses valid/ready. A transfer takes place on a clock edge where `a_valid` and `a_ready` are both high. `a_valid` must not depend on `a_ready`.

The upstream port sees the ready signal for each phase as follows:
- During the reset-release cycle it sees `a_ready` low.
- While programming it sees `a_ready` high, and every transfer is consumed as a threshold value.
- After that, `a_ready` follows `mem_ready` combinationally, and the stream passes straight through to memory.

The port-B input-ready output stays low until the thresholds are settled. This keeps the second direction closed until the configuration is complete.

Top module: `ofs_prog_ctrl`

## Requirements
- R1: While `rst_n` is low, `prog_done`, `a_ready`, `mem_valid` and `b_in_ready` are low, and all four threshold outputs read 1.
- R2: `flag_sel` is sampled only on the first clock edge after `rst_n` goes high. Later changes of `flag_sel` leave the thresholds and `prog_done` unchanged.
- R3: `flag_sel` 2'b11 loads 64, 2'b10 loads 16 and 2'b01 loads 8 into all four thresholds. `prog_done` rises on that same sampling edge.
- R4: With `flag_sel` 2'b00, the next four accepted port-A transfers are stored, from `a_data[AW-1:0]` with bit AW-1 as MSB, into `afull_a_ofs`, `aempty_b_ofs`, `afull_b_ofs` and `aempty_a_ofs`, in that order. AW is log2(DEPTH), which is 8 by default.
- R5: A stored value of 0 becomes 1, and a value above DEPTH-4 (252 by default) becomes DEPTH-4. Any other value is stored unchanged.
- R6: While programming, `a_ready` is high and `mem_valid` is low whatever `a_valid` is.
- R7: `prog_done` rises on the edge of the fourth programming transfer and stays high until reset. `b_in_ready` equals `prog_done & b_space`.
- R8: Once `prog_done` is high, `mem_valid` equals `a_valid`, `a_ready` equals `mem_ready`, `mem_data` equals `a_data`, and the thresholds hold.
- R9: A cycle with `a_valid` low during programming consumes no slot in the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Shared FIFO reset, active low, asynchronous assert |
| flag_sel | input | 2 | Threshold source select, sampled at reset release |
| a_valid | input | 1 | Port-A write stream valid |
| a_ready | output | 1 | Port-A write stream ready |
| a_data | input | DW | Port-A write data |
| mem_valid | output | 1 | Write valid toward FIFO memory |
| mem_ready | input | 1 | FIFO memory can take a word |
| mem_data | output | DW | Write data toward FIFO memory |
| b_space | input | 1 | Second FIFO has free space |
| b_in_ready | output | 1 | Gated port-B input-ready flag |
| prog_done | output | 1 | Thresholds are settled |
| afull_a_ofs | output | AW | Port-A almost-full threshold |
| aempty_b_ofs | output | AW | Port-B almost-empty threshold |
| afull_b_ofs | output | AW | Port-B almost-full threshold |
| aempty_a_ofs | output | AW | Port-A almost-empty threshold |

## Verification
The embedded properties check the following on every cycle:
- every threshold stays inside the legal window;
- thresholds change only on a preset load or a programming transfer;
- the controller never returns to its sampling phase without a reset;
- no word reaches memory and no port-B readiness appears before `prog_done`.

Only the bench scenarios can show that each preset code gives the right number and that the four writes land in the prescribed order. They also show that every possible 8-bit value is clamped correctly, and that select changes after the sampling edge do nothing. For this, the bench reprograms the block 64 times, with four consecutive data values per run, so that all 256 codes are covered.

// File: rtl/ofs_pkg.sv
`timescale 1ns/1ps
package ofs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PROG = 2'd1,
    PH_RUN  = 2'd2
  } ofs_phase_e;

  localparam int unsigned NUM_OFS = 4;
  localparam int unsigned SLOT_W  = $clog2(NUM_OFS);
endpackage

// File: rtl/ofs_phase.sv
`timescale 1ns/1ps
module ofs_phase
  import ofs_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sel,
  input  logic          last_wr,
  output ofs_phase_e    phase,
  output logic          preset_ld,
  output logic [AW-1:0] preset_val
);
  // preset load happens only on the single sampling cycle after release
  always_comb preset_ld = (phase == PH_IDLE) && (sel != 2'b00);

  always_comb begin
    unique case (sel)
      2'b11:   preset_val = AW'(64);
      2'b10:   preset_val = AW'(16);
      2'b01:   preset_val = AW'(8);
      default: preset_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: phase <= (sel != 2'b00) ? PH_RUN : PH_PROG;
        PH_PROG: if (last_wr) phase <= PH_RUN;
        default: phase <= PH_RUN;
      endcase
    end
  end

  AST_PRESET_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    preset_ld |=> phase == PH_RUN); // R3
  AST_SAMPLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    phase != PH_IDLE |=> phase != PH_IDLE); // R2
  AST_RUN_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_RUN |=> phase == PH_RUN); // R7
endmodule

// File: rtl/ofs_slot_ctr.sv
`timescale 1ns/1ps
module ofs_slot_ctr
  import ofs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  output logic [SLOT_W-1:0] slot,
  output logic              last_wr
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_OFS - 1);

  always_comb last_wr = wr && (slot == LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= '0;
    else if (wr) slot <= slot + 1'b1;
  end

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(slot)); // R9
endmodule

// File: rtl/ofs_bank.sv
`timescale 1ns/1ps
module ofs_bank
  import ofs_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [SLOT_W-1:0]          slot,
  input  logic [AW-1:0]              wdata,
  input  logic                       preset_ld,
  input  logic [AW-1:0]              preset_val,
  output logic [NUM_OFS-1:0][AW-1:0] ofs_q
);
  localparam logic [AW-1:0] MAXV = AW'(DEPTH - 4);
  localparam logic [AW-1:0] MINV = AW'(1);

  function automatic logic [AW-1:0] clamp(input logic [AW-1:0] v);
    if (v < MINV)      return MINV;
    else if (v > MAXV) return MAXV;
    else               return v;
  endfunction

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_ofs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               ofs_q[g] <= MINV;
      else if (preset_ld)                       ofs_q[g] <= clamp(preset_val);
      else if (wr && (slot == SLOT_W'(g)))      ofs_q[g] <= clamp(wdata);
    end

    AST_OFS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (ofs_q[g] >= MINV) && (ofs_q[g] <= MAXV)); // R5
    AST_OFS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !preset_ld) |=> $stable(ofs_q[g])); // R8
  end
endmodule

// File: rtl/ofs_prog_ctrl.sv
`timescale 1ns/1ps
module ofs_prog_ctrl
  import ofs_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 36,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    flag_sel,
  input  logic          a_valid,
  output logic          a_ready,
  input  logic [DW-1:0] a_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [DW-1:0] mem_data,
  input  logic          b_space,
  output logic          b_in_ready,
  output logic          prog_done,
  output logic [AW-1:0] afull_a_ofs,
  output logic [AW-1:0] aempty_b_ofs,
  output logic [AW-1:0] afull_b_ofs,
  output logic [AW-1:0] aempty_a_ofs
);
  ofs_phase_e                phase;
  logic                      preset_ld;
  logic [AW-1:0]             preset_val;
  logic                      wr;
  logic                      last_wr;
  logic [SLOT_W-1:0]         slot;
  logic [NUM_OFS-1:0][AW-1:0] ofs_q;

  always_comb begin
    prog_done  = (phase == PH_RUN);
    wr         = a_valid && (phase == PH_PROG);
    unique case (phase)
      PH_PROG: a_ready = 1'b1;
      PH_RUN:  a_ready = mem_ready;
      default: a_ready = 1'b0;
    endcase
    mem_valid  = a_valid && prog_done;
    mem_data   = a_data;
    b_in_ready = b_space && prog_done;
  end

  ofs_phase #(.AW(AW)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (flag_sel),
    .last_wr    (last_wr),
    .phase      (phase),
    .preset_ld  (preset_ld),
    .preset_val (preset_val)
  );

  ofs_slot_ctr u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr),
    .slot    (slot),
    .last_wr (last_wr)
  );

  ofs_bank #(.DEPTH(DEPTH), .AW(AW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (wr),
    .slot       (slot),
    .wdata      (a_data[AW-1:0]),
    .preset_ld  (preset_ld),
    .preset_val (preset_val),
    .ofs_q      (ofs_q)
  );

  // write order: slot 0..3
  assign afull_a_ofs  = ofs_q[0];
  assign aempty_b_ofs = ofs_q[1];
  assign afull_b_ofs  = ofs_q[2];
  assign aempty_a_ofs = ofs_q[3];

  AST_NO_EARLY_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> prog_done); // R6
  AST_B_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    b_in_ready |-> prog_done); // R7
  AST_DONE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> prog_done); // R7
endmodule

// File: tb/ofs_prog_ctrl_tb.sv
`timescale 1ns/1ps
module ofs_prog_ctrl_tb;
  localparam int DW = 36;
  localparam int AW = 8;
  localparam int MAXV = 252;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    flag_sel = 2'b00;
  logic          a_valid = 1'b0;
  logic          a_ready;
  logic [DW-1:0] a_data = '0;
  logic          mem_valid;
  logic          mem_ready = 1'b0;
  logic [DW-1:0] mem_data;
  logic          b_space = 1'b1;
  logic          b_in_ready;
  logic          prog_done;
  logic [AW-1:0] afull_a_ofs, aempty_b_ofs, afull_b_ofs, aempty_a_ofs;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  ofs_prog_ctrl #(.DEPTH(256), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flag_sel(flag_sel),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_data(mem_data),
    .b_space(b_space), .b_in_ready(b_in_ready), .prog_done(prog_done),
    .afull_a_ofs(afull_a_ofs), .aempty_b_ofs(aempty_b_ofs),
    .afull_b_ofs(afull_b_ofs), .aempty_a_ofs(aempty_a_ofs)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampv(input int v);
    if (v == 0) return 1;
    if (v > MAXV) return MAXV;
    return v;
  endfunction

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk);
    rst_n = 1'b0;
    a_valid = 1'b0;
    flag_sel = s;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic prog_write(input int v);
    @(negedge clk);
    a_valid = 1'b1;
    a_data = {{(DW-AW){1'b1}}, 8'(v)};
    #1;
    chk("R6 mem_valid while programming", mem_valid, 0);
    chk("R6 a_ready while programming", a_ready, 1);
    @(negedge clk);
    a_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    a_valid = 1'b1;
    mem_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 prog_done", prog_done, 0);
    chk("R1 a_ready", a_ready, 0);
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 b_in_ready", b_in_ready, 0);
    chk("R1 afull_a", afull_a_ofs, 1);
    chk("R1 aempty_a", aempty_a_ofs, 1);

    // R3 presets, R2 later select ignored, R8 pass-through
    for (int s = 1; s < 4; s++) begin
      int p;
      p = (s == 3) ? 64 : (s == 2) ? 16 : 8;
      do_reset(2'(s));
      chk("R3 done on sampling edge", prog_done, 1);
      chk("R3 afull_a preset", afull_a_ofs, p);
      chk("R3 aempty_b preset", aempty_b_ofs, p);
      chk("R3 afull_b preset", afull_b_ofs, p);
      chk("R3 aempty_a preset", aempty_a_ofs, p);
      flag_sel = 2'(s + 1);
      repeat (3) @(negedge clk);
      chk("R2 preset kept after select change", afull_b_ofs, p);
      chk("R2 done kept after select change", prog_done, 1);
      flag_sel = 2'b00;
      @(negedge clk);
      chk("R2 zero select ignored after edge", aempty_a_ofs, p);
      a_valid = 1'b1;
      a_data = DW'(36'h5A5A5A5A5) + DW'(s);
      mem_ready = 1'b0;
      b_space = 1'b0;
      #1;
      chk("R8 mem_valid follows a_valid", mem_valid, 1);
      chk("R8 a_ready follows mem_ready low", a_ready, 0);
      chk("R8 mem_data", mem_data, a_data);
      chk("R7 b_in_ready no space", b_in_ready, 0);
      mem_ready = 1'b1;
      b_space = 1'b1;
      #1;
      chk("R8 a_ready follows mem_ready high", a_ready, 1);
      chk("R7 b_in_ready with space", b_in_ready, 1);
      @(negedge clk);
      chk("R8 offsets hold under traffic", afull_a_ofs, p);
      a_valid = 1'b0;
      #1;
      chk("R8 mem_valid low", mem_valid, 0);
    end

    // R4/R5/R9: all 256 codes, four per programming run
    for (int base = 0; base < 256; base += 4) begin
      do_reset(2'b00);
      chk("R6 not done at start of programming", prog_done, 0);
      chk("R7 b_in_ready held low", b_in_ready, 0);
      for (int k = 0; k < 4; k++) begin
        if (k == 3) chk("R7 done low before fourth write", prog_done, 0);
        prog_write(base + k);
        if ((base % 16) == 0) begin
          @(negedge clk);  // R9 idle bubble
        end
      end
      chk("R7 done after fourth write", prog_done, 1);
      chk("R7 b_in_ready after programming", b_in_ready, 1);
      chk("R4 R5 afull_a slot 0", afull_a_ofs, clampv(base));
      chk("R4 R5 aempty_b slot 1", aempty_b_ofs, clampv(base + 1));
      chk("R4 R5 afull_b slot 2", afull_b_ofs, clampv(base + 2));
      chk("R4 R5 aempty_a slot 3", aempty_a_ofs, clampv(base + 3));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule